// File: doc/BRIEF.md
# Register Rename Table with Free Pool

This block renames one instruction per cycle. It reads the physical tags of two source registers from a map table that is indexed by architectural register number. It then gives the destination a physical register taken from a pool of free physical registers, and points the destination's map entry at that new register. The entry that the destination displaces is reported on the same cycle, together with the architectural register number. An outside recovery structure keeps this pair so that it can later put the mapping back or release the old physical register.

There are more physical registers than architectural ones. By default there are 8 architectural and 16 physical registers. After reset, architectural register i maps to physical register i, and physical registers 8 to 15 form the free pool. The sources are looked up before the destination is renamed, so an instruction that reads its own destination gets the older version. A release port returns a physical register to the pool. A restore port writes a saved mapping back into the table.

Top module: `rename_unit`

## Requirements
- R1: After reset, looking up architectural register i yields physical tag i, for every i from 0 to 7, and `reqReady` is 1.
- R2: Source tags are combinational reads of the current map. Once a rename of destination d has been accepted, every later lookup of d yields the tag that was allocated to d.
- R3: When a source names the same architectural register as the destination of the same request, the source tag is the mapping held before that request, which equals `oldTag`.
- R4: `dstTag` is the lowest-numbered free physical register. Right after reset, successive renames receive 8, 9, 10 and onward, in ascending order.
- R5: `oldTag` is the map entry of `reqDst` before the rename, and `oldArch` equals `reqDst`.
- R6: `reqReady` is 0 while the free pool is empty. A request made while `reqReady` is 0 changes neither the map nor the pool.
- R7: A tag presented on the release port with `relValid`=1 is back in the pool from the next cycle, and it is allocated again if it is the lowest free tag.
- R8: A restore (`rstrValid`=1) writes `rstrTag` into the entry for `rstrArch` at the clock edge. In the same cycle it holds `reqReady` at 0, so that no rename takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Rename request present |
| reqSrcA | input | 3 | First source architectural register |
| reqSrcB | input | 3 | Second source architectural register |
| reqDst | input | 3 | Destination architectural register |
| reqReady | output | 1 | A request is accepted at this edge if valid |
| srcATag | output | 4 | Physical tag of first source |
| srcBTag | output | 4 | Physical tag of second source |
| dstTag | output | 4 | Physical tag allocated to destination |
| oldTag | output | 4 | Displaced mapping of destination |
| oldArch | output | 3 | Architectural register of displaced mapping |
| relValid | input | 1 | Release a physical register to the pool |
| relTag | input | 4 | Physical register being released |
| rstrValid | input | 1 | Restore a saved mapping |
| rstrArch | input | 3 | Architectural register to restore |
| rstrTag | input | 4 | Physical tag to write back |

## Verification
A corrupted map entry shows up at the ports as soon as a later request reads that register as a source or as a destination. The bad tag appears in `srcATag`, `srcBTag` or `oldTag` in that same combinational cycle. A fault in the free pool shows up in `dstTag` at the next accepted rename, either as a tag out of ascending order or as the reuse of a tag that was never released. When the pool's count goes wrong, `reqReady` changes at the wrong rename. The bench therefore reads back every touched entry after each step and drains the pool to exactly empty.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 16;
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);

  typedef logic [AW-1:0] archTag_t;
  typedef logic [PW-1:0] physTag_t;

  typedef struct packed {
    logic allocEn;    // take the lowest free tag out of the pool
    logic mapWrEn;    // point the destination entry at the new tag
    logic restoreEn;  // write back a saved mapping
    logic releaseEn;  // return a tag to the pool
  } strobes_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     relValid,
  input  logic     rstrValid,
  input  logic     freeAny,
  output logic     reqReady,
  output strobes_t strobes
);
  logic fire;

  // A restore owns the map write port for its cycle, so renames wait.
  assign reqReady = freeAny && !rstrValid;
  assign fire     = reqValid && reqReady;

  always_comb begin
    strobes           = '0;
    strobes.allocEn   = fire;
    strobes.mapWrEn   = fire;
    strobes.restoreEn = rstrValid;
    strobes.releaseEn = relValid;
  end

  a_r8_restore_blocks: assert property (@(posedge clk) disable iff (!rstN)
    rstrValid |-> !reqReady);

  a_r6_no_grant_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !freeAny |-> !strobes.allocEn);
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strobes,
  input  archTag_t reqSrcA,
  input  archTag_t reqSrcB,
  input  archTag_t reqDst,
  input  physTag_t relTag,
  input  archTag_t rstrArch,
  input  physTag_t rstrTag,
  output logic     freeAny,
  output physTag_t srcATag,
  output physTag_t srcBTag,
  output physTag_t dstTag,
  output physTag_t oldTag,
  output archTag_t oldArch
);
  physTag_t mapTbl [ARCH_REGS];
  logic [PHYS_REGS-1:0] freeVec;
  logic [PHYS_REGS-1:0] freeNext;
  physTag_t allocTag;

  // One register per map entry; entry i resets to physical register i.
  for (genvar g = 0; g < ARCH_REGS; g++) begin : gMap
    always_ff @(posedge clk) begin
      if (!rstN)
        mapTbl[g] <= physTag_t'(g);
      else if (strobes.restoreEn && rstrArch == archTag_t'(g))
        mapTbl[g] <= rstrTag;
      else if (strobes.mapWrEn && reqDst == archTag_t'(g))
        mapTbl[g] <= allocTag;
    end
  end

  // Lowest-index free tag wins.
  always_comb begin
    allocTag = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--)
      if (freeVec[i]) allocTag = physTag_t'(i);
  end

  assign freeAny = |freeVec;

  always_comb begin
    freeNext = freeVec;
    if (strobes.allocEn)   freeNext[allocTag] = 1'b0;
    if (strobes.releaseEn) freeNext[relTag]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++)
        freeVec[i] <= (i >= ARCH_REGS);
    end else begin
      freeVec <= freeNext;
    end
  end

  // Sources read the map before this cycle's destination write lands.
  assign srcATag = mapTbl[reqSrcA];
  assign srcBTag = mapTbl[reqSrcB];
  assign oldTag  = mapTbl[reqDst];
  assign oldArch = reqDst;
  assign dstTag  = allocTag;

  a_r6_alloc_needs_free: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocEn |-> freeVec[allocTag]);

  a_r4_alloc_leaves_pool: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.allocEn && !(strobes.releaseEn && relTag == allocTag))
      |=> !freeVec[$past(allocTag)]);

  a_r7_release_joins_pool: assert property (@(posedge clk) disable iff (!rstN)
    strobes.releaseEn |=> freeVec[$past(relTag)]);

  a_r2_map_takes_new_tag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mapWrEn && !strobes.restoreEn)
      |=> mapTbl[$past(reqDst)] == $past(allocTag));

  a_r8_restore_writes_map: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restoreEn |=> mapTbl[$past(rstrArch)] == $past(rstrTag));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [AW-1:0]    reqSrcA,
  input  logic [AW-1:0]    reqSrcB,
  input  logic [AW-1:0]    reqDst,
  output logic             reqReady,
  output logic [PW-1:0]    srcATag,
  output logic [PW-1:0]    srcBTag,
  output logic [PW-1:0]    dstTag,
  output logic [PW-1:0]    oldTag,
  output logic [AW-1:0]    oldArch,
  input  logic             relValid,
  input  logic [PW-1:0]    relTag,
  input  logic             rstrValid,
  input  logic [AW-1:0]    rstrArch,
  input  logic [PW-1:0]    rstrTag
);
  strobes_t strobes;
  logic     freeAny;

  rename_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .relValid  (relValid),
    .rstrValid (rstrValid),
    .freeAny   (freeAny),
    .reqReady  (reqReady),
    .strobes   (strobes)
  );

  rename_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqSrcA  (reqSrcA),
    .reqSrcB  (reqSrcB),
    .reqDst   (reqDst),
    .relTag   (relTag),
    .rstrArch (rstrArch),
    .rstrTag  (rstrTag),
    .freeAny  (freeAny),
    .srcATag  (srcATag),
    .srcBTag  (srcBTag),
    .dstTag   (dstTag),
    .oldTag   (oldTag),
    .oldArch  (oldArch)
  );
endmodule

// File: tb/rename_unit_test.sv
module rename_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqSrcA = '0, reqSrcB = '0, reqDst = '0;
  logic       reqReady;
  logic [3:0] srcATag, srcBTag, dstTag, oldTag;
  logic [2:0] oldArch;
  logic       relValid = 1'b0;
  logic [3:0] relTag = '0;
  logic       rstrValid = 1'b0;
  logic [2:0] rstrArch = '0;
  logic [3:0] rstrTag = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  rename_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrcA(reqSrcA),
    .reqSrcB(reqSrcB), .reqDst(reqDst), .reqReady(reqReady),
    .srcATag(srcATag), .srcBTag(srcBTag), .dstTag(dstTag), .oldTag(oldTag),
    .oldArch(oldArch), .relValid(relValid), .relTag(relTag),
    .rstrValid(rstrValid), .rstrArch(rstrArch), .rstrTag(rstrTag)
  );

  // {srcA, srcB, dst, expSrcA, expSrcB, expDst, expOld}
  localparam int NVEC = 5;
  localparam logic [24:0] VEC [NVEC] = '{
    {3'd1, 3'd2, 3'd1, 4'd1,  4'd2, 4'd8,  4'd1},   // R4 first alloc is 8
    {3'd1, 3'd1, 3'd3, 4'd8,  4'd8, 4'd9,  4'd3},   // R2 reads new version
    {3'd3, 3'd0, 3'd3, 4'd9,  4'd0, 4'd10, 4'd9},   // R3 self read sees old
    {3'd3, 3'd1, 3'd0, 4'd10, 4'd8, 4'd11, 4'd0},
    {3'd0, 3'd7, 3'd7, 4'd11, 4'd7, 4'd12, 4'd7}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] arch, input int exp, input string req);
    @(negedge clk);
    reqValid = 0; relValid = 0; rstrValid = 0;
    reqSrcA = arch;
    #1 check(req, int'(srcATag), exp);
  endtask

  task automatic rename(input logic [2:0] a, input logic [2:0] b,
                        input logic [2:0] d, output int tag);
    @(negedge clk);
    relValid = 0; rstrValid = 0;
    reqValid = 1; reqSrcA = a; reqSrcB = b; reqDst = d;
    #1 tag = int'(dstTag);
    @(posedge clk);
    #1 reqValid = 0;
  endtask

  initial begin
    int t;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: identity map after reset
    for (int i = 0; i < 8; i++) peek(3'(i), i, "R1");
    check("R1 ready", int'(reqReady), 1);

    // Table-driven renames
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      reqValid = 1;
      reqSrcA = VEC[v][24:22]; reqSrcB = VEC[v][21:19]; reqDst = VEC[v][18:16];
      #1;
      check("R2 srcA", int'(srcATag), int'(VEC[v][15:12]));
      check("R2 srcB", int'(srcBTag), int'(VEC[v][11:8]));
      check("R4 dst",  int'(dstTag),  int'(VEC[v][7:4]));
      check("R5 old",  int'(oldTag),  int'(VEC[v][3:0]));
      check("R5 arch", int'(oldArch), int'(VEC[v][18:16]));
      if (VEC[v][24:22] == VEC[v][18:16])
        check("R3 self", int'(srcATag), int'(oldTag));
      @(posedge clk);
      #1 reqValid = 0;
    end
    peek(3'd3, 10, "R2 after");
    peek(3'd7, 12, "R2 after");

    // R7: release tag 1, then it is lowest free
    @(negedge clk);
    relValid = 1; relTag = 4'd1;
    @(posedge clk);
    #1 relValid = 0;
    rename(3'd2, 3'd2, 3'd2, t);
    check("R7 reuse", t, 1);
    peek(3'd2, 1, "R7 map");

    // R8: restore blocks a concurrent rename and writes the map
    @(negedge clk);
    rstrValid = 1; rstrArch = 3'd3; rstrTag = 4'd3;
    reqValid = 1; reqDst = 3'd6;
    #1 check("R8 ready", int'(reqReady), 0);
    @(posedge clk);
    #1 begin rstrValid = 0; reqValid = 0; end
    peek(3'd3, 3, "R8 restored");
    peek(3'd6, 6, "R8 no rename");

    // R6: drain 13, 14, 15
    rename(3'd4, 3'd4, 3'd4, t); check("R4 order", t, 13);
    rename(3'd4, 3'd4, 3'd4, t); check("R4 order", t, 14);
    rename(3'd4, 3'd4, 3'd4, t); check("R4 order", t, 15);
    @(negedge clk);
    #1 check("R6 empty", int'(reqReady), 0);
    reqValid = 1; reqDst = 3'd5;
    @(posedge clk);
    #1 reqValid = 0;
    peek(3'd5, 5, "R6 map held");
    peek(3'd4, 15, "R6 map held");

    // Release 9: pool refills, rename gets 9
    @(negedge clk);
    relValid = 1; relTag = 4'd9;
    @(posedge clk);
    #1 relValid = 0;
    #1 check("R7 ready", int'(reqReady), 1);
    rename(3'd5, 3'd0, 3'd5, t);
    check("R7 refill", t, 9);
    peek(3'd5, 9, "R2 final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule